// File: doc/BRIEF.md
# Beam-Width Pulse Placement Calculator

This block turns a requested beam pulse width into a complete set of timing parameters for the pulses that depend on it. Those pulses are the electron-gun drive, the RF drive, and two data-sampling triggers. The gun and RF pulses are stretched beyond the beam by a per-pulse extra width, and they begin earlier than the beam by a per-pulse lead. One sampling trigger sits a fixed offset after the beam begins. The other sits a fixed offset before the beam ends. The result set is meant to be loaded into a bank of one-shot timers.

A request carries the beam width and the repetition period, both in microseconds. The six margins are also taken in microseconds, and they are captured together with the request. The request is first checked against width, period and duty-factor limits and against the ordering of the two triggers. A request that fails any of these checks produces a one-cycle error strobe with a code. A request that passes is placed in microseconds and then scaled into timebase ticks, rounded to the nearest tick. All eight results then appear at once with a one-cycle valid strobe.

The controller has four states. `ST_IDLE` accepts a request. `ST_CHECK` runs the limit checks. `ST_PLACE` computes the positions in microseconds. `ST_CONVERT` scales them into ticks. The transitions are as follows:
- IDLE→CHECK on `req_valid`.
- CHECK→IDLE on a rejection.
- CHECK→PLACE on a pass.
- PLACE→CONVERT unconditionally.
- CONVERT→IDLE unconditionally.

Top module: `pulse_place_calc`

## Requirements
- R1: During and after reset, `busy`, `res_valid` and `err_valid` are 0, `err_code` is 0, and every tick output is 0.
- R2: A request is accepted on a rising edge where `req_valid` is 1 and `busy` is 0, and `busy` is 1 from that edge until the request finishes. A `req_valid` seen while `busy` is 1 is ignored, and so is a change to the margin inputs while `busy` is 1. Neither produces a result.
- R3: A width below 12 us is rejected with code 1, and a width above 1000 us is rejected with code 2. Both limits are inclusive, so widths of exactly 12 and 1000 pass.
- R4: A period below 2000 us or above 1000000 us is rejected with code 3.
- R5: A request where width×1000 > period×20 (duty factor above 2%) is rejected with code 4. Equality passes.
- R6: A request where width ≤ early offset + late offset is rejected with code 5. This is the case where the late trigger would not fall after the early trigger. When several checks fail, the lowest code is reported.
- R7: A rejection raises `err_valid` for exactly one cycle, after the second rising edge counted from the accepting edge as edge 1. `res_valid` stays 0 and the tick outputs keep their previous values.
- R8: The beam start equals the larger of the two leads. The gun delay equals the beam start minus the gun lead, and the gun width equals the width plus the gun extra. The RF delay and RF width are formed the same way from the RF lead and RF extra. The beam delay output is the beam start, and the beam width output is the width.
- R9: The early trigger equals the beam start plus the early offset. The late trigger equals the beam start plus the width minus the late offset.
- R10: Every microsecond value u is presented as ticks = (u×537 + 128) >> 8. This is the rate of 537/256 ticks per microsecond, rounded to the nearest tick.
- R11: An accepted request raises `res_valid` for exactly one cycle, after the fourth rising edge counted from the accepting edge. All eight tick outputs change in that cycle and hold until the next result.
- R12: A request presented in the same cycle as `res_valid` or `err_valid` is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_width_us | input | 10 | Beam width in us |
| req_period_us | input | 20 | Repetition period in us |
| gun_lead_us | input | 8 | Gun start ahead of beam, us |
| gun_extra_us | input | 8 | Gun width beyond beam, us |
| rf_lead_us | input | 8 | RF start ahead of beam, us |
| rf_extra_us | input | 8 | RF width beyond beam, us |
| early_off_us | input | 8 | Early trigger after beam start, us |
| late_off_us | input | 8 | Late trigger before beam end, us |
| busy | output | 1 | Request in progress |
| res_valid | output | 1 | One-cycle result strobe |
| beam_delay_tk | output | 16 | Beam start, ticks |
| beam_width_tk | output | 16 | Beam width, ticks |
| gun_delay_tk | output | 16 | Gun start, ticks |
| gun_width_tk | output | 16 | Gun width, ticks |
| rf_delay_tk | output | 16 | RF start, ticks |
| rf_width_tk | output | 16 | RF width, ticks |
| early_tk | output | 16 | Early trigger position, ticks |
| late_tk | output | 16 | Late trigger position, ticks |
| err_valid | output | 1 | One-cycle rejection strobe |
| err_code | output | 3 | Rejection code, 1 to 5 |

## Verification
Two functions can land in the same cycle: a result or rejection strobe can coincide with the acceptance of the next request. The bench provokes this by presenting a second request in exactly the cycle where `res_valid` is seen. It then judges that the first result stays intact and that the second result arrives four edges after its own acceptance, with values that belong to the second request alone. A related collision is a request that arrives while the block is busy. The bench checks that such a request, together with margin changes made during the same cycle, leaves the pending result untouched and adds no extra strobe.

// File: rtl/pulse_place_pkg.sv
package pulse_place_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PLACE,
        ST_CONVERT
    } state_t;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_WID_LOW  = 3'd1,
        ERR_WID_HIGH = 3'd2,
        ERR_PERIOD   = 3'd3,
        ERR_DUTY     = 3'd4,
        ERR_ORDER    = 3'd5
    } err_t;

    localparam int NUM_FIELDS = 8;
    localparam int F_BEAM_DLY = 0;
    localparam int F_BEAM_WID = 1;
    localparam int F_GUN_DLY  = 2;
    localparam int F_GUN_WID  = 3;
    localparam int F_RF_DLY   = 4;
    localparam int F_RF_WID   = 5;
    localparam int F_EARLY    = 6;
    localparam int F_LATE     = 7;

endpackage

// File: rtl/pulse_place_limits.sv
module pulse_place_limits
    import pulse_place_pkg::*;
#(
    parameter int WID_W       = 10,
    parameter int PER_W       = 20,
    parameter int MRG_W       = 8,
    parameter int MIN_WID     = 12,
    parameter int MAX_WID     = 1000,
    parameter int MIN_PER     = 2000,
    parameter int MAX_PER     = 1000000,
    parameter int DUTY_PERMIL = 20
) (
    input  logic [WID_W-1:0] width_us,
    input  logic [PER_W-1:0] period_us,
    input  logic [MRG_W-1:0] early_us,
    input  logic [MRG_W-1:0] late_us,
    output err_t             code
);
    localparam int PROD_W = PER_W + 16;

    logic [PROD_W-1:0] duty_lhs;
    logic [PROD_W-1:0] duty_rhs;
    logic [MRG_W:0]    trig_sum;

    assign duty_lhs = PROD_W'(width_us) * PROD_W'(1000);
    assign duty_rhs = PROD_W'(period_us) * PROD_W'(DUTY_PERMIL);
    assign trig_sum = {1'b0, early_us} + {1'b0, late_us};

    // Priority: lowest code wins.
    always_comb begin
        if (int'(width_us) < MIN_WID)
            code = ERR_WID_LOW;
        else if (int'(width_us) > MAX_WID)
            code = ERR_WID_HIGH;
        else if (int'(period_us) < MIN_PER || int'(period_us) > MAX_PER)
            code = ERR_PERIOD;
        else if (duty_lhs > duty_rhs)
            code = ERR_DUTY;
        else if (int'(width_us) <= int'(trig_sum))
            code = ERR_ORDER;
        else
            code = ERR_NONE;
    end
endmodule

// File: rtl/pulse_place_geom.sv
module pulse_place_geom
    import pulse_place_pkg::*;
#(
    parameter int WID_W = 10,
    parameter int MRG_W = 8,
    parameter int POS_W = 12
) (
    input  logic [WID_W-1:0] width_us,
    input  logic [MRG_W-1:0] gun_lead,
    input  logic [MRG_W-1:0] gun_extra,
    input  logic [MRG_W-1:0] rf_lead,
    input  logic [MRG_W-1:0] rf_extra,
    input  logic [MRG_W-1:0] early_off,
    input  logic [MRG_W-1:0] late_off,
    output logic [POS_W-1:0] pos [NUM_FIELDS]
);
    logic [POS_W-1:0] beam_start;
    logic [POS_W-1:0] wid;

    assign beam_start = (gun_lead > rf_lead) ? POS_W'(gun_lead) : POS_W'(rf_lead);
    assign wid        = POS_W'(width_us);

    always_comb begin
        pos[F_BEAM_DLY] = beam_start;
        pos[F_BEAM_WID] = wid;
        pos[F_GUN_DLY]  = beam_start - POS_W'(gun_lead);
        pos[F_GUN_WID]  = wid + POS_W'(gun_extra);
        pos[F_RF_DLY]   = beam_start - POS_W'(rf_lead);
        pos[F_RF_WID]   = wid + POS_W'(rf_extra);
        pos[F_EARLY]    = beam_start + POS_W'(early_off);
        pos[F_LATE]     = beam_start + wid - POS_W'(late_off);
    end
endmodule

// File: rtl/pulse_place_tick.sv
module pulse_place_tick #(
    parameter int POS_W     = 12,
    parameter int TICK_W    = 16,
    parameter int RATE_Q    = 8,
    parameter int TICK_RATE = 537
) (
    input  logic [POS_W-1:0]  us_val,
    output logic [TICK_W-1:0] tick_val
);
    localparam int PROD_W = POS_W + TICK_W + RATE_Q;

    logic [PROD_W-1:0] scaled;

    assign scaled   = PROD_W'(us_val) * PROD_W'(TICK_RATE) + PROD_W'(1 << (RATE_Q - 1));
    assign tick_val = scaled[RATE_Q +: TICK_W];
endmodule

// File: rtl/pulse_place_calc.sv
module pulse_place_calc
    import pulse_place_pkg::*;
#(
    parameter int WID_W       = 10,
    parameter int PER_W       = 20,
    parameter int MRG_W       = 8,
    parameter int TICK_W      = 16,
    parameter int RATE_Q      = 8,
    parameter int TICK_RATE   = 537,
    parameter int MIN_WID     = 12,
    parameter int MAX_WID     = 1000,
    parameter int MIN_PER     = 2000,
    parameter int MAX_PER     = 1000000,
    parameter int DUTY_PERMIL = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WID_W-1:0]  req_width_us,
    input  logic [PER_W-1:0]  req_period_us,
    input  logic [MRG_W-1:0]  gun_lead_us,
    input  logic [MRG_W-1:0]  gun_extra_us,
    input  logic [MRG_W-1:0]  rf_lead_us,
    input  logic [MRG_W-1:0]  rf_extra_us,
    input  logic [MRG_W-1:0]  early_off_us,
    input  logic [MRG_W-1:0]  late_off_us,
    output logic              busy,
    output logic              res_valid,
    output logic [TICK_W-1:0] beam_delay_tk,
    output logic [TICK_W-1:0] beam_width_tk,
    output logic [TICK_W-1:0] gun_delay_tk,
    output logic [TICK_W-1:0] gun_width_tk,
    output logic [TICK_W-1:0] rf_delay_tk,
    output logic [TICK_W-1:0] rf_width_tk,
    output logic [TICK_W-1:0] early_tk,
    output logic [TICK_W-1:0] late_tk,
    output logic              err_valid,
    output logic [2:0]        err_code
);
    localparam int POS_W = ((WID_W > MRG_W) ? WID_W : MRG_W) + 2;

    state_t            state_q, state_d;
    err_t              chk_code;
    logic [WID_W-1:0]  wid_q;
    logic [PER_W-1:0]  per_q;
    logic [MRG_W-1:0]  gl_q, ge_q, rl_q, re_q, eo_q, lo_q;
    logic [POS_W-1:0]  pos_d  [NUM_FIELDS];
    logic [POS_W-1:0]  pos_q  [NUM_FIELDS];
    logic [TICK_W-1:0] tick_d [NUM_FIELDS];
    logic [TICK_W-1:0] tick_q [NUM_FIELDS];

    pulse_place_limits #(
        .WID_W(WID_W), .PER_W(PER_W), .MRG_W(MRG_W),
        .MIN_WID(MIN_WID), .MAX_WID(MAX_WID),
        .MIN_PER(MIN_PER), .MAX_PER(MAX_PER),
        .DUTY_PERMIL(DUTY_PERMIL)
    ) limits_i (
        .width_us (wid_q),
        .period_us(per_q),
        .early_us (eo_q),
        .late_us  (lo_q),
        .code     (chk_code)
    );

    pulse_place_geom #(
        .WID_W(WID_W), .MRG_W(MRG_W), .POS_W(POS_W)
    ) geom_i (
        .width_us (wid_q),
        .gun_lead (gl_q),
        .gun_extra(ge_q),
        .rf_lead  (rl_q),
        .rf_extra (re_q),
        .early_off(eo_q),
        .late_off (lo_q),
        .pos      (pos_d)
    );

    generate
        for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_conv
            pulse_place_tick #(
                .POS_W(POS_W), .TICK_W(TICK_W),
                .RATE_Q(RATE_Q), .TICK_RATE(TICK_RATE)
            ) conv_i (
                .us_val  (pos_q[gi]),
                .tick_val(tick_d[gi])
            );
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_CHECK;
            ST_CHECK:   state_d = (chk_code != ERR_NONE) ? ST_IDLE : ST_PLACE;
            ST_PLACE:   state_d = ST_CONVERT;
            ST_CONVERT: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            err_valid <= 1'b0;
            err_code  <= 3'd0;
            wid_q <= '0; per_q <= '0;
            gl_q <= '0; ge_q <= '0; rl_q <= '0; re_q <= '0; eo_q <= '0; lo_q <= '0;
            for (int i = 0; i < NUM_FIELDS; i++) begin
                pos_q[i]  <= '0;
                tick_q[i] <= '0;
            end
        end else begin
            res_valid <= 1'b0;
            err_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        wid_q <= req_width_us;
                        per_q <= req_period_us;
                        gl_q  <= gun_lead_us;
                        ge_q  <= gun_extra_us;
                        rl_q  <= rf_lead_us;
                        re_q  <= rf_extra_us;
                        eo_q  <= early_off_us;
                        lo_q  <= late_off_us;
                    end
                end
                ST_CHECK: begin
                    if (chk_code != ERR_NONE) begin
                        err_valid <= 1'b1;
                        err_code  <= chk_code;
                    end
                end
                ST_PLACE: begin
                    for (int i = 0; i < NUM_FIELDS; i++) pos_q[i] <= pos_d[i];
                end
                ST_CONVERT: begin
                    for (int i = 0; i < NUM_FIELDS; i++) tick_q[i] <= tick_d[i];
                    res_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign beam_delay_tk = tick_q[F_BEAM_DLY];
    assign beam_width_tk = tick_q[F_BEAM_WID];
    assign gun_delay_tk  = tick_q[F_GUN_DLY];
    assign gun_width_tk  = tick_q[F_GUN_WID];
    assign rf_delay_tk   = tick_q[F_RF_DLY];
    assign rf_width_tk   = tick_q[F_RF_WID];
    assign early_tk      = tick_q[F_EARLY];
    assign late_tk       = tick_q[F_LATE];
endmodule

// File: rtl/pulse_place_calc_chk.sv
module pulse_place_calc_chk #(
    parameter int TICK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              res_valid,
    input logic              err_valid,
    input logic [2:0]        err_code,
    input logic [TICK_W-1:0] beam_width_tk,
    input logic [TICK_W-1:0] gun_width_tk,
    input logic [TICK_W-1:0] rf_width_tk,
    input logic [TICK_W-1:0] early_tk,
    input logic [TICK_W-1:0] late_tk
);
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    assert_err_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code != 3'd0 && err_code <= 3'd5));

    assert_err_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (!res_valid && !busy));

    assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    assert_widths_cover_beam_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (gun_width_tk >= beam_width_tk && rf_width_tk >= beam_width_tk));

    assert_trigger_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (late_tk > early_tk));

    assert_res_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_hold_between_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(beam_width_tk) && $stable(gun_width_tk) &&
                        $stable(rf_width_tk) && $stable(early_tk) && $stable(late_tk)));
endmodule

bind pulse_place_calc pulse_place_calc_chk #(.TICK_W(TICK_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .res_valid    (res_valid),
    .err_valid    (err_valid),
    .err_code     (err_code),
    .beam_width_tk(beam_width_tk),
    .gun_width_tk (gun_width_tk),
    .rf_width_tk  (rf_width_tk),
    .early_tk     (early_tk),
    .late_tk      (late_tk)
);

// File: tb/pulse_place_calc_tb_top.sv
`timescale 1ns/1ps
module pulse_place_calc_tb_top;

    typedef struct packed {
        logic [9:0]  wid;
        logic [19:0] per;
        logic [7:0]  gl, ge, rl, re, eo, lo;
        logic [2:0]  err;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{10'd100,  20'd10000,   8'd5,   8'd4,   8'd3, 8'd6, 8'd10,  8'd20,  3'd0}, // R8 R9 R10
        '{10'd12,   20'd2000,    8'd0,   8'd0,   8'd0, 8'd0, 8'd5,   8'd6,   3'd0}, // R3 R4 lower edges pass
        '{10'd1000, 20'd1000000, 8'd255, 8'd255, 8'd7, 8'd1, 8'd255, 8'd255, 3'd0}, // R3 R4 upper edges pass
        '{10'd11,   20'd10000,   8'd1,   8'd1,   8'd1, 8'd1, 8'd1,   8'd1,   3'd1}, // R3 low
        '{10'd1001, 20'd1000000, 8'd1,   8'd1,   8'd1, 8'd1, 8'd1,   8'd1,   3'd2}, // R3 high
        '{10'd100,  20'd1999,    8'd1,   8'd1,   8'd1, 8'd1, 8'd1,   8'd1,   3'd3}, // R4 + duty, R6 priority
        '{10'd100,  20'd1000001, 8'd1,   8'd1,   8'd1, 8'd1, 8'd1,   8'd1,   3'd3}, // R4 high
        '{10'd500,  20'd20000,   8'd1,   8'd1,   8'd1, 8'd1, 8'd1,   8'd1,   3'd4}, // R5 exceed
        '{10'd400,  20'd20000,   8'd1,   8'd1,   8'd1, 8'd1, 8'd1,   8'd1,   3'd0}, // R5 equal passes
        '{10'd30,   20'd10000,   8'd1,   8'd1,   8'd1, 8'd1, 8'd15,  8'd15,  3'd5}, // R6 equal rejected
        '{10'd31,   20'd10000,   8'd1,   8'd1,   8'd1, 8'd1, 8'd15,  8'd15,  3'd0}, // R6 one above passes
        '{10'd50,   20'd5000,    8'd2,   8'd3,   8'd9, 8'd4, 8'd7,   8'd8,   3'd0}  // R8 RF lead larger
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  req_width_us = '0;
    logic [19:0] req_period_us = '0;
    logic [7:0]  gun_lead_us = '0, gun_extra_us = '0, rf_lead_us = '0, rf_extra_us = '0;
    logic [7:0]  early_off_us = '0, late_off_us = '0;
    logic        busy, res_valid, err_valid;
    logic [2:0]  err_code;
    logic [15:0] beam_delay_tk, beam_width_tk, gun_delay_tk, gun_width_tk;
    logic [15:0] rf_delay_tk, rf_width_tk, early_tk, late_tk;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pulse_place_calc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_width_us(req_width_us), .req_period_us(req_period_us),
        .gun_lead_us(gun_lead_us), .gun_extra_us(gun_extra_us),
        .rf_lead_us(rf_lead_us), .rf_extra_us(rf_extra_us),
        .early_off_us(early_off_us), .late_off_us(late_off_us),
        .busy(busy), .res_valid(res_valid),
        .beam_delay_tk(beam_delay_tk), .beam_width_tk(beam_width_tk),
        .gun_delay_tk(gun_delay_tk), .gun_width_tk(gun_width_tk),
        .rf_delay_tk(rf_delay_tk), .rf_width_tk(rf_width_tk),
        .early_tk(early_tk), .late_tk(late_tk),
        .err_valid(err_valid), .err_code(err_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R10 rounding rule
    function automatic int tk(input int us);
        return (us * 537 + 128) >>> 8;
    endfunction

    task automatic drive(input vec_t v);
        req_width_us  = v.wid;  req_period_us = v.per;
        gun_lead_us   = v.gl;   gun_extra_us  = v.ge;
        rf_lead_us    = v.rl;   rf_extra_us   = v.re;
        early_off_us  = v.eo;   late_off_us   = v.lo;
    endtask

    // Presents v, counts edges from acceptance (edge 1) to the first strobe.
    task automatic do_req(input vec_t v, input bit synced, output int n);
        if (!synced) @(negedge clk);
        drive(v);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        for (int k = 0; k < 20; k++) begin
            if (res_valid || err_valid) break;
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_result(input string tag, input vec_t v);
        int bs;
        bs = (v.gl > v.rl) ? int'(v.gl) : int'(v.rl);
        check({tag, " R8 beam_delay"}, int'(beam_delay_tk), tk(bs));
        check({tag, " R8 beam_width"}, int'(beam_width_tk), tk(int'(v.wid)));
        check({tag, " R8 gun_delay"},  int'(gun_delay_tk),  tk(bs - int'(v.gl)));
        check({tag, " R8 gun_width"},  int'(gun_width_tk),  tk(int'(v.wid) + int'(v.ge)));
        check({tag, " R8 rf_delay"},   int'(rf_delay_tk),   tk(bs - int'(v.rl)));
        check({tag, " R8 rf_width"},   int'(rf_width_tk),   tk(int'(v.wid) + int'(v.re)));
        check({tag, " R9 early"},      int'(early_tk),      tk(bs + int'(v.eo)));
        check({tag, " R9 late"},       int'(late_tk),       tk(bs + int'(v.wid) - int'(v.lo)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int prev_bw;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 res_valid", int'(res_valid), 0);
        check("R1 err_valid", int'(err_valid), 0);
        check("R1 err_code", int'(err_code), 0);
        check("R1 late_tk", int'(late_tk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", int'(busy), 0);

        // Vector walk: R3..R11
        for (int i = 0; i < NV; i++) begin
            prev_bw = int'(beam_width_tk);
            do_req(VECS[i], 1'b0, n);
            if (VECS[i].err == 3'd0) begin
                check($sformatf("R11 vec%0d latency", i), n, 4);
                check($sformatf("R11 vec%0d res_valid", i), int'(res_valid), 1);
                check_result($sformatf("vec%0d", i), VECS[i]);
                @(negedge clk);
                check($sformatf("R11 vec%0d one-cycle strobe", i), int'(res_valid), 0);
            end else begin
                check($sformatf("R7 vec%0d latency", i), n, 2);
                check($sformatf("R3-6 vec%0d err_code", i), int'(err_code), int'(VECS[i].err));
                check($sformatf("R7 vec%0d no result", i), int'(res_valid), 0);
                check($sformatf("R7 vec%0d outputs held", i), int'(beam_width_tk), prev_bw);
                @(negedge clk);
                check($sformatf("R7 vec%0d one-cycle strobe", i), int'(err_valid), 0);
            end
        end

        // R2: request and margin change while busy are ignored
        @(negedge clk);
        drive(VECS[0]);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 busy after accept", int'(busy), 1);
        drive(VECS[2]);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 2;
        for (int k = 0; k < 20; k++) begin
            if (res_valid || err_valid) break;
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check("R2 latency unaffected", n, 4);
        check_result("R2 first request kept", VECS[0]);
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (res_valid || err_valid) n++;
        end
        check("R2 no extra strobe", n, 0);

        // R12: request in the same cycle as the result strobe
        do_req(VECS[11], 1'b0, n);
        check("R12 first latency", int'(res_valid), 1);
        check_result("R12 first", VECS[11]);
        do_req(VECS[1], 1'b1, n);
        check("R12 second latency", n, 4);
        check_result("R12 second", VECS[1]);

        // R12: request in the same cycle as the error strobe
        do_req(VECS[7], 1'b0, n);
        check("R12 err strobe", int'(err_valid), 1);
        do_req(VECS[10], 1'b1, n);
        check("R12 after error latency", n, 4);
        check_result("R12 after error", VECS[10]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule